// File: doc/BRIEF.md
# Serial-Programmed Clock Output Enable Bank

This block sits beside a multi-output clock buffer and decides which of its outputs toggle. An I2C controller programs a small bank of 8-bit enable registers; each bit of the bank gates one copy of a reference clock. A bit at 1 lets the reference clock through to its output, and a bit at 0 holds that output low. The bus pins are sampled by a faster system clock, so the block needs no logic clocked by SCL.

Writes always use block-write framing. After the slave address come two bytes, a command byte and a count byte, which are acknowledged and then dropped. Every byte after them lands in the next register, starting at register 0. There is no register pointer, and the count byte does not limit the transfer: only STOP ends it. A read returns the bank from register 0 upward. An active-low power-down input releases the bus and makes the slave ignore traffic, while the stored settings stay as they are. SCL is only ever an input, since the slave never stretches the clock.

Top module: `clk_enable_i2c`

## Requirements
- R1: The 7-bit slave address is a parameter (default 0x69), sent MSB first with the read/write bit last (1 = read). On a match the slave pulls SDA low in the ninth clock (ACK). On a mismatch it leaves SDA released and ignores every bit and byte until the next START.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged and never stored, whatever their values.
- R3: Each later data byte is written to the next register, starting at register 0 in every write transaction and moving up by one per byte.
- R4: A STOP after any complete data byte keeps the bytes already written and leaves the higher registers unchanged. A partial byte cut off by STOP is not stored.
- R5: Data bytes past the last register (default bank of 6) are acknowledged and discarded.
- R6: A read returns register 0, 1, 2, ... in order, and 0xFF for any position past the last register. A NACK from the controller ends the transfer.
- R7: After reset, register 0 holds 0x00 and every other register holds 0xFF.
- R8: Output index r*8+b follows bit b of register r. At 1 the output copies ref_clk, and at 0 it is held low.
- R9: An output's gating changes only while ref_clk is low, so an output never shows a shortened pulse.
- R10: While pwr_dn_n is low, SDA is released, bus traffic is ignored and all register contents are kept.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ref_clk | input | 1 | Reference clock to distribute |
| clk_out | output | 48 | Gated copies of ref_clk |

## Verification
The bench sends random block writes of zero to eight data bytes, sometimes running past the bank, and reads them back with random lengths. A design that stored the command or count byte, or did not restart at register 0, would show shifted readback. A design that wrapped its pointer would overwrite low registers, and one that returned stale data past the bank would miss the 0xFF check. Directed cases cut a byte short with STOP, send a foreign address followed by data, and issue traffic during power-down. A wrong design here would keep the partial byte, acknowledge or store foreign traffic, or lose its settings. Output edges are timed against the reference clock, so a gate that switches mid-pulse shows up as an edge off the reference grid.

// File: rtl/ckg_pkg.sv
`timescale 1ns/1ps
package ckg_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RECV, ST_ACK, ST_SEND, ST_MACK
  } bus_state_e;
endpackage

// File: rtl/ckg_line_sampler.sv
`timescale 1ns/1ps
module ckg_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_pin};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_pin};
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl   = scl_sync[SYNC_STAGES-1];
  assign sda_lvl   = sda_sync[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ckg_bus_engine.sv
`timescale 1ns/1ps
module ckg_bus_engine
  import ckg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG  = 6,
  parameter int IDX_W = $clog2(NREG),
  parameter int PTR_W = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic             sda_oe,
  output bus_state_e       state
);
  localparam logic [PTR_W-1:0] END_PTR = PTR_W'(NREG);

  logic [3:0]        bit_cnt;
  logic [1:0]        hdr_cnt;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rd_mode, nack;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      hdr_cnt <= '0;
      ptr     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rd_mode <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!pwr_ok) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        hdr_cnt <= '0;
        ptr     <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_RECV: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[7:1] == DEV_ADDR) begin
                  rd_mode <= rx_sh[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                if (hdr_cnt != 2'd2) begin
                  hdr_cnt <= hdr_cnt + 1'b1;
                end else if (ptr < END_PTR) begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr[IDX_W-1:0];
                  wr_data <= rx_sh;
                  ptr     <= ptr + 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rd_mode) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                state  <= ST_SEND;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RECV;
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                if (ptr < END_PTR) ptr <= ptr + 1'b1;
              end else begin
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_sh[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                tx_sh   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_SEND;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ckg_enable_bank.sv
`timescale 1ns/1ps
module ckg_enable_bank
  import ckg_pkg::*;
#(
  parameter int NREG  = 6,
  parameter int IDX_W = $clog2(NREG),
  parameter int PTR_W = $clog2(NREG + 1),
  parameter int NOUT  = NREG * BYTE_W,
  parameter logic [NOUT-1:0] RST_VEC = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [NOUT-1:0]   en_bits
);
  logic [BYTE_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= RST_VEC[g*BYTE_W +: BYTE_W];
      end else if (wr_en && wr_addr == IDX_W'(g)) begin
        regs[g] <= wr_data;
      end
    end
    assign en_bits[g*BYTE_W +: BYTE_W] = regs[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == PTR_W'(k)) rd_data = regs[k];
    end
  end
endmodule

// File: rtl/ckg_gate_bank.sv
`timescale 1ns/1ps
module ckg_gate_bank #(
  parameter int NOUT = 48,
  parameter logic [NOUT-1:0] RST_VEC = '1
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic [NOUT-1:0] en_in,
  output logic [NOUT-1:0] clk_out
);
  logic [NOUT-1:0] en_q;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_q <= RST_VEC;
    else        en_q <= en_in;
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_gate
    assign clk_out[i] = ref_clk & en_q[i];
  end
endmodule

// File: rtl/clk_enable_i2c.sv
`timescale 1ns/1ps
module clk_enable_i2c
  import ckg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 6,
  parameter int SYNC_STAGES = 2,
  parameter int NOUT = NREG * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_dn_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            ref_clk,
  output logic [NOUT-1:0] clk_out
);
  localparam int IDX_W = $clog2(NREG);
  localparam int PTR_W = $clog2(NREG + 1);
  localparam logic [NOUT-1:0] RST_VEC = {{(NOUT-BYTE_W){1'b1}}, {BYTE_W{1'b0}}};

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [PTR_W-1:0]  rd_addr;
  logic [NOUT-1:0]   en_bits;
  bus_state_e        eng_state;

  ckg_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_i), .sda_pin(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  ckg_bus_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_dn_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe), .state(eng_state)
  );

  ckg_enable_bank #(.NREG(NREG), .IDX_W(IDX_W), .PTR_W(PTR_W), .NOUT(NOUT), .RST_VEC(RST_VEC)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .en_bits(en_bits)
  );

  ckg_gate_bank #(.NOUT(NOUT), .RST_VEC(RST_VEC)) u_gates (
    .ref_clk(ref_clk), .rst_n(rst_n), .en_in(en_bits), .clk_out(clk_out)
  );
endmodule

// File: rtl/ckg_i2c_chk.sv
`timescale 1ns/1ps
module ckg_i2c_chk
  import ckg_pkg::*;
#(
  parameter int NREG  = 6,
  parameter int IDX_W = $clog2(NREG),
  parameter int NOUT  = NREG * 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn_n,
  input logic             scl_lvl,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic [NOUT-1:0]  en_bits,
  input bus_state_e       state
);
  localparam logic [NOUT-1:0] RST_VEC = {{(NOUT-8){1'b1}}, 8'h00};

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_bits));

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NREG));

  // R7
  rst_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_bits == RST_VEC));

  // R10
  pwrdn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |=> !sda_oe);

  // R11
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_dn_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));
endmodule

bind clk_enable_i2c ckg_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .scl_lvl(scl_lvl),
  .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .en_bits(en_bits),
  .state(eng_state)
);

// File: tb/clk_enable_i2c_test.sv
`timescale 1ns/1ps
module clk_enable_i2c_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int NREG = 6;
  localparam int NOUT = NREG * 8;
  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0, ref_clk = 1'b0;
  logic rst_n = 1'b0, pwr_dn_n = 1'b1;
  logic scl_m = 1'b1, sda_low = 1'b0;
  logic sda_oe;
  logic [NOUT-1:0] clk_out;
  wire sda_line = ~(sda_low | sda_oe);

  int n_tests = 0, n_fail = 0, glitches = 0, sda_viol = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7 ref_clk = ~ref_clk;

  clk_enable_i2c uut (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .scl_i(scl_m),
    .sda_i(sda_line), .sda_oe(sda_oe), .ref_clk(ref_clk), .clk_out(clk_out)
  );

  // R9 monitor: output edges must sit on the ref_clk grid
  always @(clk_out) if (($time % 7) != 0) glitches++;
  // R11 monitor: slave drive changes only while SCL low
  always @(sda_oe) if (rst_n && scl_m) sda_viol++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_low = 1'b0; scl_m = 1'b1; w(Q);
    sda_low = 1'b1; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_low = 1'b1; w(Q);
    scl_m = 1'b1; w(Q);
    sda_low = 1'b0; w(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_low = ~b; w(Q);
    scl_m = 1'b1; w(2*Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_low = 1'b0; w(Q);
    scl_m = 1'b1; w(Q);
    b = sda_line; w(Q);
    scl_m = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit last);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(last);
  endtask

  // block write of nd data bytes from wbuf[2..], wbuf[0..1] are header
  task automatic do_write(input logic [6:0] a, input int nd, input bit exp_ack, input string req);
    bit ack;
    bus_start;
    put_byte({a, 1'b0}, ack);
    chk(ack == exp_ack, exp_ack ? "R1" : req, 64'(ack), 64'(exp_ack));
    for (int i = 0; i < nd + 2; i++) begin
      put_byte(wbuf[i], ack);
      if (exp_ack) begin
        chk(ack, (i < 2) ? "R2" : ((i - 2 >= NREG) ? "R5" : "R3"), 64'(ack), 64'd1);
        if (i >= 2 && i - 2 < NREG) model[i-2] = wbuf[i];
      end else begin
        chk(!ack, req, 64'(ack), 64'd0);
      end
    end
    bus_stop;
  endtask

  task automatic do_read(input int n, input string req);
    bit ack;
    logic [7:0] v;
    bus_start;
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R1", 64'(ack), 64'd1);
    for (int i = 0; i < n; i++) begin
      get_byte(v, i == n - 1);
      if (i < NREG) chk(v == model[i], req, 64'(v), 64'(model[i]));
      else          chk(v == 8'hFF, "R6", 64'(v), 64'hFF);
    end
    bus_stop;
  endtask

  task automatic check_gate(input string req);
    logic [NOUT-1:0] ev;
    for (int r = 0; r < NREG; r++) ev[r*8 +: 8] = model[r];
    repeat (2) @(negedge ref_clk);
    @(posedge ref_clk); #3;
    chk(clk_out == ev, req, 64'(clk_out), 64'(ev));
    @(negedge ref_clk); #3;
    chk(clk_out == '0, "R8", 64'(clk_out), 64'd0);
  endtask

  initial begin
    #1900000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic b;
    void'($urandom(32'h5EED_C10C));
    model[0] = 8'h00;
    for (int r = 1; r < NREG; r++) model[r] = 8'hFF;
    w(5);
    rst_n = 1'b1;
    w(5);
    chk(sda_oe == 1'b0, "R7", 64'(sda_oe), 64'd0);
    check_gate("R7");
    do_read(NREG + 2, "R7");

    // full write running past the bank
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h31 + 8'(i * 17));
    wbuf[1] = 8'h02;  // count byte value is not a length
    do_write(ADDR, 8, 1'b1, "R3");
    do_read(NREG + 2, "R6");
    check_gate("R8");

    // STOP after two data bytes
    wbuf[2] = 8'h0F; wbuf[3] = 8'hF0;
    do_write(ADDR, 2, 1'b1, "R4");
    do_read(NREG, "R4");

    // header only: nothing stored
    wbuf[0] = 8'h00; wbuf[1] = 8'h06;
    do_write(ADDR, 0, 1'b1, "R2");
    do_read(NREG, "R2");

    // partial byte cut by STOP
    bus_start;
    put_byte({ADDR, 1'b0}, ack); chk(ack, "R1", 64'(ack), 64'd1);
    put_byte(8'h11, ack); put_byte(8'h22, ack);
    put_byte(8'hA5, ack); chk(ack, "R4", 64'(ack), 64'd1);
    model[0] = 8'hA5;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop;
    do_read(NREG, "R4");

    // foreign address: ignored
    for (int i = 0; i < 6; i++) wbuf[i] = 8'h00;
    do_write(ADDR ^ 7'h01, 4, 1'b0, "R1");
    do_read(NREG, "R1");
    check_gate("R1");

    // power-down: no ack, no change, settings kept
    pwr_dn_n = 1'b0; w(4);
    chk(sda_oe == 1'b0, "R10", 64'(sda_oe), 64'd0);
    do_write(ADDR, 4, 1'b0, "R10");
    check_gate("R10");
    pwr_dn_n = 1'b1; w(4);
    do_read(NREG, "R10");

    // random block writes and reads
    for (int it = 0; it < 14; it++) begin
      int nd, nr;
      nd = int'($urandom_range(0, 8));
      nr = int'($urandom_range(1, 8));
      for (int i = 0; i < nd + 2; i++) wbuf[i] = 8'($urandom);
      do_write(ADDR, nd, 1'b1, "R3");
      do_read(nr, "R6");
      if (it % 4 == 0) check_gate("R8");
    end

    // a read then directly a write restarts at register 0
    wbuf[0] = 8'h55; wbuf[1] = 8'h55; wbuf[2] = 8'h3C;
    do_write(ADDR, 1, 1'b1, "R3");
    do_read(1, "R3");
    check_gate("R8");

    chk(glitches == 0, "R9", 64'(glitches), 64'd0);
    chk(sda_viol == 0, "R11", 64'(sda_viol), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule